// File: doc/BRIEF.md
# Serial Receive Path with Error Status

The block takes an asynchronous serial line and turns it into characters. The line is oversampled by a baud tick that runs at sixteen times the bit rate. Each bit is sampled once, at the middle of its period. A character can have 5 to 8 data bits, sent LSB first, an optional parity bit (even, odd or stick) and one or two stop bits. Every completed character is stored in a 16-entry receive queue, together with three error bits: break, parity and framing.

Software-facing logic around the block pops the queue one entry at a time. When an entry is popped, its error bits are OR-ed into a four-bit status word. The status word also holds an overrun flag, which is set when a character completes while the queue is full. That character is discarded and the queue contents are kept unchanged. The block also recognises a line that stays low for longer than one whole frame. It logs this as a single zero character marked as a break, and then ignores the line until it has returned high.

Top module: `srx_core`

## Requirements
- R1: After reset: `rx_status` = 0, `fifo_empty` = 1, `fifo_full` = 0, `rd_data` = 0, `rd_err` = 0.
- R2: With `cfg_data_bits` = n (n = 0..3), a character has 5+n data bits, received LSB first. Each bit is sampled once per 16 baud ticks, at mid-bit. The value appears zero-extended on `rd_data`.
- R3: With `cfg_par_en` = 1 and `cfg_stick` = 0, the expected parity bit is the XOR of the data bits when `cfg_even` = 1, and its inverse when `cfg_even` = 0. A mismatch sets entry error bit 1 (parity).
- R4: With `cfg_par_en` = 1 and `cfg_stick` = 1, the expected parity bit is the inverse of `cfg_even`: 0 for even, 1 for odd.
- R5: If any sampled stop bit (one or two, selected by `cfg_two_stop`) is 0, entry error bit 0 (framing) is set.
- R6: A start bit whose half-bit sample finds the line high is treated as a glitch and stores nothing.
- R7: When the line is low for more than 16·(1 + data + parity + stop) ticks, exactly one entry is stored, with data 0 and error bits 3'b100 (break only). A character that is all zero, including its stop bits, and lasts exactly one frame is stored as a framing error, not as a break.
- R8: After a break, nothing more is received until the line goes high. The next start bit after that is received normally.
- R9: The queue holds 16 entries. A pop on a non-empty queue loads the oldest entry onto `rd_data`/`rd_err` at the next clock. A pop on an empty queue changes nothing.
- R10: A character that completes while the queue is full is dropped, the stored entries are unchanged, and `rx_status[3]` is set. The next accepted pop clears `rx_status[3]`.
- R11: `rx_status` bits: [3] overrun, [2] break, [1] parity, [0] framing. On a pop, the popped entry's error bits (break, parity, framing) are OR-ed into bits [2:0], which otherwise hold their value.
- R12: A pulse on `stat_clr` clears all four status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_data_bits | input | 2 | Data length minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Stick parity select |
| cfg_two_stop | input | 1 | Two stop bits |
| pop | input | 1 | Read strobe for the receive queue |
| stat_clr | input | 1 | Clears the status word |
| rd_data | output | 8 | Data of the last popped entry |
| rd_err | output | 3 | Error bits of the last popped entry: [2] break, [1] parity, [0] framing |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds 16 entries |
| rx_status | output | 4 | Sticky status word |

## Verification
The hardest case to reach is the edge between a long all-zero character and a break. It is reached by holding the line low for exactly one frame time, which must give one framing-error entry. A second run holds the line low for longer, which must give one break entry, and the line then stays low for several more frame times to show that no further entry appears. Overrun is reached by sending seventeen back-to-back characters without popping, then draining the queue to show that the first sixteen survived in order. A reference model in the bench holds the queue and the status word, and its contents are compared with the ports on every clock while the line is idle.

// File: rtl/srx_pkg.sv
// Shared types for the serial receive path.
// Assumes characters are at most eight data bits wide.
package srx_pkg;
    localparam int DATA_W = 8;

    // Bit positions inside the status word
    localparam int ST_OVR = 3;
    localparam int ST_BRK = 2;
    localparam int ST_PAR = 1;
    localparam int ST_FRM = 0;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } srx_err_t;

    typedef struct packed {
        srx_err_t              err;
        logic [DATA_W-1:0]     data;
    } srx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_DEFER,
        RX_WAITHI
    } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
// Two-or-more stage synchroniser for the serial input.
// Assumes STAGES >= 2; resets to the idle (high) line level.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
// Character assembler: start detection with glitch rejection, mid-bit
// sampling, parity and stop checks, and break detection.
// Assumes a synchronised line and configuration held stable during a frame.
module srx_framer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_data_bits,
    input  logic       cfg_par_en,
    input  logic       cfg_even,
    input  logic       cfg_stick,
    input  logic       cfg_two_stop,
    output logic       push_vld,
    output srx_entry_t push_ent
);
    localparam int OCW      = $clog2(OVS);
    localparam int BIW      = $clog2(DATA_W);
    localparam int MAX_BITS = 1 + DATA_W + 1 + 2;
    localparam int LCW      = $clog2(OVS * MAX_BITS + 2);

    srx_state_e        state_q;
    logic [OCW-1:0]    os_q;
    logic [BIW-1:0]    bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              pacc_q;
    logic              perr_q;
    logic              ferr_q;
    logic              stop2_q;
    logic              hi_q;
    logic [LCW-1:0]    low_q;

    logic [BIW-1:0]    last_bit;
    logic [LCW-1:0]    frame_ticks;
    logic              at_mid;
    logic              at_end;
    logic              exp_par;
    logic              fe_now;

    assign last_bit    = BIW'(int'(cfg_data_bits) + 4);
    assign frame_ticks = LCW'(OVS * (7 + int'(cfg_data_bits) + int'(cfg_par_en)
                                       + int'(cfg_two_stop)));
    assign at_mid      = (os_q == OCW'(OVS / 2 - 1));
    assign at_end      = (os_q == OCW'(OVS - 1));
    assign exp_par     = cfg_stick ? ~cfg_even : (cfg_even ? pacc_q : ~pacc_q);
    assign fe_now      = ferr_q | ~rx;

    // Count consecutive low ticks for break detection, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (tick) begin
            if (rx)               low_q <= '0;
            else if (low_q != '1) low_q <= low_q + 1'b1;
        end
    end

    // Frame sequencing and single-cycle push of finished characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            os_q     <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            pacc_q   <= 1'b0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            stop2_q  <= 1'b0;
            hi_q     <= 1'b0;
            push_vld <= 1'b0;
            push_ent <= '0;
        end else begin
            push_vld <= 1'b0;
            if (tick) begin
                if (rx && (state_q == RX_START || state_q == RX_DATA ||
                           state_q == RX_PAR   || state_q == RX_STOP))
                    hi_q <= 1'b1;
                unique case (state_q)
                    RX_IDLE: begin
                        if (!rx) begin
                            state_q <= RX_START;
                            os_q    <= '0;
                            bit_q   <= '0;
                            sh_q    <= '0;
                            pacc_q  <= 1'b0;
                            perr_q  <= 1'b0;
                            ferr_q  <= 1'b0;
                            stop2_q <= 1'b0;
                            hi_q    <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (at_mid) begin
                            os_q    <= '0;
                            state_q <= rx ? RX_IDLE : RX_DATA;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_end) begin
                            os_q        <= '0;
                            sh_q[bit_q] <= rx;
                            pacc_q      <= pacc_q ^ rx;
                            if (bit_q == last_bit)
                                state_q <= cfg_par_en ? RX_PAR : RX_STOP;
                            else
                                bit_q <= bit_q + 1'b1;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (at_end) begin
                            os_q    <= '0;
                            perr_q  <= (rx != exp_par);
                            state_q <= RX_STOP;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_end) begin
                            os_q <= '0;
                            if (cfg_two_stop && !stop2_q) begin
                                stop2_q <= 1'b1;
                                ferr_q  <= fe_now;
                            end else if (fe_now && !(hi_q | rx)) begin
                                ferr_q  <= 1'b1;
                                state_q <= RX_DEFER;
                            end else begin
                                push_vld     <= 1'b1;
                                push_ent     <= '{err: '{brk: 1'b0, par: perr_q, frm: fe_now},
                                                  data: sh_q};
                                state_q      <= RX_IDLE;
                            end
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_DEFER: begin
                        if (rx) begin
                            push_vld <= 1'b1;
                            push_ent <= '{err: '{brk: 1'b0, par: perr_q, frm: 1'b1},
                                          data: sh_q};
                            state_q  <= RX_IDLE;
                        end else if (low_q >= frame_ticks) begin
                            push_vld <= 1'b1;
                            push_ent <= '{err: '{brk: 1'b1, par: 1'b0, frm: 1'b0},
                                          data: '0};
                            state_q  <= RX_WAITHI;
                        end
                    end
                    RX_WAITHI: begin
                        if (rx) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
// Receive queue with a registered read port.
// Assumes a write while full is refused and reported on drop.
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  srx_entry_t wr_ent,
    input  logic       rd_en,
    output srx_entry_t rd_ent,
    output srx_entry_t head_ent,
    output logic       empty,
    output logic       full,
    output logic       drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    srx_entry_t     mem_q [DEPTH];
    logic [AW-1:0]  wptr_q;
    logic [AW-1:0]  rptr_q;
    logic [CW-1:0]  cnt_q;
    logic           wr_ok;
    logic           rd_ok;

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign wr_ok    = wr_en && !full;
    assign rd_ok    = rd_en && !empty;
    assign drop     = wr_en && full;
    assign head_ent = mem_q[rptr_q];

    // Store accepted entries
    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wptr_q] <= wr_ent;
    end

    // Pointer, occupancy and read register upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rd_ent <= '0;
        end else begin
            if (wr_ok)
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (rd_ok) begin
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
                rd_ent <= mem_q[rptr_q];
            end
            cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/srx_status.sv
// Sticky four-bit status word.
// Assumes head_err belongs to the entry being popped in the same cycle.
module srx_status
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       pop_ok,
    input  srx_err_t   head_err,
    input  logic       drop,
    output logic [3:0] stat
);
    logic [3:0] nxt;

    // Clear first, then fold in this cycle's events
    always_comb begin
        nxt = stat;
        if (clr) nxt = '0;
        if (pop_ok) begin
            nxt[ST_OVR]        = 1'b0;
            nxt[ST_BRK:ST_FRM] = nxt[ST_BRK:ST_FRM] | head_err;
        end
        if (drop) nxt[ST_OVR] = 1'b1;
    end

    // Hold the status word
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= nxt;
    end
endmodule

// File: rtl/srx_core.sv
// Top of the serial receive path: synchroniser, character assembler,
// receive queue and status word. Assumes baud_tick pulses at OVS times
// the bit rate and that the configuration changes only while idle.
module srx_core
    import srx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DEPTH    = 16,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic [1:0]        cfg_data_bits,
    input  logic              cfg_par_en,
    input  logic              cfg_even,
    input  logic              cfg_stick,
    input  logic              cfg_two_stop,
    input  logic              pop,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        rd_err,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [3:0]        rx_status
);
    logic       rx_s;
    logic       push_vld;
    srx_entry_t push_ent;
    srx_entry_t rd_ent;
    srx_entry_t head_ent;
    logic       drop;

    srx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    srx_framer #(.OVS(OVS)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (baud_tick),
        .rx           (rx_s),
        .cfg_data_bits(cfg_data_bits),
        .cfg_par_en   (cfg_par_en),
        .cfg_even     (cfg_even),
        .cfg_stick    (cfg_stick),
        .cfg_two_stop (cfg_two_stop),
        .push_vld     (push_vld),
        .push_ent     (push_ent)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_vld),
        .wr_ent  (push_ent),
        .rd_en   (pop),
        .rd_ent  (rd_ent),
        .head_ent(head_ent),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .drop    (drop)
    );

    srx_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .pop_ok  (pop && !fifo_empty),
        .head_err(head_ent.err),
        .drop    (drop),
        .stat    (rx_status)
    );

    assign rd_data = rd_ent.data;
    assign rd_err  = rd_ent.err;
endmodule

// File: rtl/srx_core_chk.sv
// Property checker for srx_core, attached by bind.
module srx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pop,
    input logic       stat_clr,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic [7:0] rd_data,
    input logic [2:0] rd_err,
    input logic [3:0] status,
    input logic       push_vld,
    input logic [7:0] push_data,
    input logic       push_brk,
    input logic       push_par,
    input logic       push_frm
);
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R9

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_empty) |=> ($stable(rd_data) && $stable(rd_err))); // R9

    AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && fifo_full && !pop) |=> status[3]); // R10

    AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && fifo_full && !pop) |=> fifo_full); // R10

    AST_POP_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !fifo_empty && !(push_vld && fifo_full)) |=> !status[3]); // R10

    AST_BRK_ZERO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && push_brk) |-> (push_data == 8'h00 && !push_par && !push_frm)); // R7

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !pop) |=> (status[2:0] == 3'b000)); // R12

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !pop) |=> (status[2:0] == $past(status[2:0]))); // R11
endmodule

bind srx_core srx_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .stat_clr  (stat_clr),
    .fifo_empty(fifo_empty),
    .fifo_full (fifo_full),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .status    (rx_status),
    .push_vld  (push_vld),
    .push_data (push_ent.data),
    .push_brk  (push_ent.err.brk),
    .push_par  (push_ent.err.par),
    .push_frm  (push_ent.err.frm)
);

// File: tb/srx_core_tb.sv
// Self-checking bench: behavioural queue/status model compared every idle clock.
module srx_core_tb;
    localparam int OVS   = 16;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_data_bits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       pop = 1'b0;
    logic       stat_clr = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic       fifo_empty;
    logic       fifo_full;
    logic [3:0] rx_status;

    srx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .cfg_data_bits(cfg_data_bits), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop), .pop(pop),
        .stat_clr(stat_clr), .rd_data(rd_data), .rd_err(rd_err),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .rx_status(rx_status)
    );

    always #4 clk = ~clk;

    int tdiv = 1;
    int tcnt = 0;
    always @(posedge clk) begin
        baud_tick <= (tcnt >= tdiv - 1);
        tcnt      <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
    end

    int errors = 0;
    int checks = 0;
    logic [10:0] mq[$];
    logic [7:0]  m_rd = 8'h00;
    logic [2:0]  m_err = 3'b000;
    logic [3:0]  m_stat = 4'h0;
    bit          mvalid = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model while the line is quiet
    always @(negedge clk) begin
        if (mvalid) begin
            chk("R9",  32'(fifo_empty), 32'(mq.size() == 0), "empty");
            chk("R9",  32'(fifo_full), 32'(mq.size() == DEPTH), "full");
            chk("R2",  32'(rd_data), 32'(m_rd), "rd_data");
            chk("R11", 32'(rd_err), 32'(m_err), "rd_err");
            chk("R11", 32'(rx_status), 32'(m_stat), "status");
        end
    end

    function automatic void m_push(input logic [2:0] e, input logic [7:0] d);
        if (mq.size() == DEPTH) m_stat[3] = 1'b1;
        else                    mq.push_back({e, d});
    endfunction

    function automatic logic par_of(input logic [7:0] d, input int nd, input logic even);
        logic x = 1'b0;
        for (int i = 0; i < nd; i++) x ^= d[i];
        return even ? x : ~x;
    endfunction

    task automatic do_pop();
        @(negedge clk); pop = 1'b1;
        @(posedge clk); #1; pop = 1'b0;
        if (mq.size() > 0) begin
            {m_err, m_rd} = mq.pop_front();
            m_stat[2:0] |= m_err;
            m_stat[3] = 1'b0;
        end
    endtask

    task automatic do_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(posedge clk); #1; stat_clr = 1'b0;
        m_stat = 4'h0;
    endtask

    task automatic pop_check(input string tag, input logic [7:0] d, input logic [2:0] e);
        do_pop();
        @(negedge clk);
        chk(tag, 32'(rd_data), 32'(d), "popped data");
        chk(tag, 32'(rd_err), 32'(e), "popped error bits");
    endtask

    task automatic drive(input logic b, input int n);
        rx_line = b;
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; the model learns the expected entry after the idle gap
    task automatic frame(input int nd, input logic [7:0] d, input logic use_par,
                         input logic pbit, input logic s1, input logic s2,
                         input logic [2:0] exp_err);
        int bt = OVS * tdiv;
        mvalid = 1'b0;
        @(negedge clk);
        drive(1'b0, bt);
        for (int i = 0; i < nd; i++) drive(d[i], bt);
        if (use_par) drive(pbit, bt);
        drive(s1, bt);
        if (cfg_two_stop) drive(s2, bt);
        drive(1'b1, 3 * bt);
        m_push(exp_err, d & 8'((1 << nd) - 1));
        mvalid = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(rx_status), 0, "status after reset");
        chk("R1", 32'(fifo_empty), 1, "empty after reset");
        chk("R1", 32'(fifo_full), 0, "full after reset");
        chk("R1", 32'(rd_data), 0, "rd_data after reset");
        chk("R1", 32'(rd_err), 0, "rd_err after reset");
        mvalid = 1'b1;

        // R2 plain 8-bit character
        frame(8, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000);
        pop_check("R2", 8'hA5, 3'b000);

        // R3 7-bit even parity, correct
        cfg_data_bits = 2'd2; cfg_par_en = 1'b1; cfg_even = 1'b1;
        frame(7, 8'h35, 1'b1, par_of(8'h35, 7, 1'b1), 1'b1, 1'b1, 3'b000);
        pop_check("R3", 8'h35, 3'b000);

        // R2 R3 5-bit odd parity, two stops
        cfg_data_bits = 2'd0; cfg_even = 1'b0; cfg_two_stop = 1'b1;
        frame(5, 8'h1B, 1'b1, par_of(8'h1B, 5, 1'b0), 1'b1, 1'b1, 3'b000);
        pop_check("R2", 8'h1B, 3'b000);

        // R3 wrong parity, R11 flag moves into status on pop, R12 clear
        cfg_data_bits = 2'd3; cfg_even = 1'b1; cfg_two_stop = 1'b0;
        frame(8, 8'h0F, 1'b1, ~par_of(8'h0F, 8, 1'b1), 1'b1, 1'b1, 3'b010);
        chk("R11", 32'(rx_status), 0, "status before pop");
        pop_check("R3", 8'h0F, 3'b010);
        chk("R11", 32'(rx_status), 32'h2, "parity flag in status");
        do_clr();
        @(negedge clk);
        chk("R12", 32'(rx_status), 0, "status after clear");

        // R4 stick parity
        cfg_stick = 1'b1; cfg_even = 1'b1;
        frame(8, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1, 3'b000);
        frame(8, 8'h57, 1'b1, 1'b1, 1'b1, 1'b1, 3'b010);
        cfg_even = 1'b0;
        frame(8, 8'h57, 1'b1, 1'b1, 1'b1, 1'b1, 3'b000);
        pop_check("R4", 8'h55, 3'b000);
        pop_check("R4", 8'h57, 3'b010);
        pop_check("R4", 8'h57, 3'b000);
        cfg_stick = 1'b0; cfg_par_en = 1'b0;
        do_clr();

        // R5 framing: single stop low, then second of two stops low
        frame(8, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001);
        cfg_two_stop = 1'b1;
        frame(8, 8'h42, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001);
        cfg_two_stop = 1'b0;
        pop_check("R5", 8'h81, 3'b001);
        pop_check("R5", 8'h42, 3'b001);
        chk("R5", 32'(rx_status), 32'h1, "framing flag in status");
        do_clr();

        // R6 short low pulse is a glitch
        @(negedge clk);
        drive(1'b0, 5);
        drive(1'b1, 3 * OVS);
        chk("R6", 32'(fifo_empty), 1, "no entry after glitch");

        // R7 boundary: all-zero for exactly one frame gives framing, not break
        mvalid = 1'b0;
        drive(1'b0, 10 * OVS);
        drive(1'b1, 3 * OVS);
        m_push(3'b001, 8'h00);
        mvalid = 1'b1;
        pop_check("R7", 8'h00, 3'b001);
        do_clr();

        // R7 break and R8 suspension until the line is high
        mvalid = 1'b0;
        drive(1'b0, 11 * OVS);
        m_push(3'b100, 8'h00);
        drive(1'b0, 40 * OVS);
        chk("R8", 32'(fifo_empty), 0, "break entry present");
        drive(1'b1, 3 * OVS);
        mvalid = 1'b1;
        frame(8, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000);
        pop_check("R7", 8'h00, 3'b100);
        chk("R7", 32'(rx_status), 32'h4, "break flag in status");
        pop_check("R8", 8'h3C, 3'b000);
        chk("R8", 32'(fifo_empty), 1, "only one break entry");
        do_clr();

        // R10 overrun: 17 frames into a 16-deep queue
        for (int i = 0; i < DEPTH + 1; i++)
            frame(8, 8'(8'h10 + i), 1'b0, 1'b0, 1'b1, 1'b1, 3'b000);
        chk("R10", 32'(fifo_full), 1, "full after 16");
        chk("R10", 32'(rx_status), 32'h8, "overrun flag");
        pop_check("R10", 8'h10, 3'b000);
        chk("R10", 32'(rx_status), 0, "overrun cleared by pop");
        for (int i = 1; i < DEPTH; i++) pop_check("R10", 8'(8'h10 + i), 3'b000);

        // R9 pop while empty changes nothing
        chk("R9", 32'(fifo_empty), 1, "drained");
        pop_check("R9", 8'h1F, 3'b000);

        // R2 slower tick: 6-bit character with ticks every third clock
        tdiv = 3; cfg_data_bits = 2'd1;
        repeat (6) @(negedge clk);
        frame(6, 8'h2A, 1'b0, 1'b0, 1'b1, 1'b1, 3'b000);
        pop_check("R2", 8'h2A, 3'b000);

        mvalid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule